// File: doc/BRIEF.md
# Register Write-Protection Controller with One-Way Lock

This block sits on a simple 32-bit register bus and guards a small set of configuration registers against later writes. It keeps one protection bit per guarded group. Software raises protection through one register, lowers it through a second, and can lock any bit through a third. Once a bit is locked, it can still be raised but can no longer be lowered.

The block holds two of the guarded registers itself: a 3-bit region-configuration register and a 1-bit region-select register. It also gates the write strobe for an external address window that holds the translation-control and table-base pair. A write that targets a protected register is dropped without any error, and the register keeps its old value. Reads are never blocked. Read data comes back one cycle after the read strobe.

Top module: `wprot_ctrl`

## Requirements
- R1: After synchronous reset, all protection and lock bits are zero. Both guarded registers read 0, and all three entries of `guard_open_o` are 1.
- R2: A write to offset 0x200 sets every protection bit whose write-data bit is 1 and leaves the other bits unchanged. Offsets 0x200 and 0x204 both read back the current protection bits.
- R3: A write to offset 0x204 clears every protection bit whose write-data bit is 1, as long as that bit is not locked.
- R4: A write to offset 0x208 sets every lock bit whose write-data bit is 1. Lock bits can be cleared only by reset. Offset 0x208 reads back the lock bits.
- R5: A locked protection bit ignores writes to offset 0x204, while writes to offset 0x200 still set it.
- R6: Only bits 4:0 are implemented. Bits 31:5 of every read are zero, and writing 1s to them changes nothing.
- R7: Protection bits 1 and 2 can be set and read back, but they gate nothing. `guard_open_o` bits are {~bit4, ~bit3, ~bit0} of the protection state, in the order [2:0].
- R8: The 3-bit register at offset 0x500 takes write-data bits 2:0 when protection bit 3 is clear. When bit 3 is set, the write is dropped and the old value is kept. It reads back zero-extended.
- R9: The 1-bit register at offset 0x504 takes write-data bit 0 when protection bit 4 is clear. When bit 4 is set, the write is dropped.
- R10: `xlat_wr_o` is 1 in a cycle with a bus write whose word address falls inside the translation window (byte offsets 0x040 to 0x07C by default), but only when protection bit 0 is clear. Otherwise it is 0.
- R11: A write that changes protection takes effect from the next cycle. A guarded write in the cycle right after a protect write is already dropped.
- R12: `bus_rvalid` is 1 exactly one cycle after `bus_rd`, and `bus_rdata` then holds the addressed value. An unmapped offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| xlat_wr_o | output | 1 | Gated write strobe for the external translation register window |
| guard_open_o | output | 3 | Write allowed per group: [0] translation pair, [1] region config, [2] region select |
| region_cfg_o | output | 3 | Region-configuration register value |
| region_sel_o | output | 1 | Region-select register value |

## Verification
The bench checks the cases where a set-only rule and a clear rule meet:
- Locked bits survive a write to the unprotect register, while unlocked bits beside them still clear. A design that applied the lock globally, or not at all, would read back the wrong mask.
- A write of zeros to the lock register leaves the lock unchanged, and upper write-data bits are ignored. A design that used plain stores instead of OR-updates would lose or gain bits here.
- The bench places a guarded write in the very next cycle after a protect write, and also writes to guarded registers while only their neighbouring bits are set. A design with a delayed or mis-wired gate would let those writes through, or block the wrong register.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int PROT_BITS = 5;

    localparam logic [ADDR_W-1:0] OFS_PROT   = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_UNPROT = 12'h204;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 12'h208;
    localparam logic [ADDR_W-1:0] OFS_RCFG   = 12'h500;
    localparam logic [ADDR_W-1:0] OFS_RSEL   = 12'h504;

    // Protection bit that gates each guarded group
    localparam int BIT_XLAT = 0;
    localparam int BIT_RCFG = 3;
    localparam int BIT_RSEL = 4;

    localparam int RCFG_W  = 3;
    localparam int RSEL_W  = 1;
    localparam int N_GROUP = 3;

    // One-hot view of which register an access targets
    typedef struct packed {
        logic prot;
        logic unprot;
        logic lock;
        logic rcfg;
        logic rsel;
        logic xlat;
    } hit_t;

    function automatic logic word_match(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] ofs);
        return a[ADDR_W-1:2] == ofs[ADDR_W-1:2];
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int unsigned       words);
        logic [ADDR_W-1:0] lim;
        lim = base + ADDR_W'(words * 4);
        return (a >= base) && (a < lim);
    endfunction

endpackage

// File: rtl/wprot_decode.sv
module wprot_decode
    import wprot_pkg::*;
#(
    parameter logic [ADDR_W-1:0] XLAT_BASE  = 12'h040,
    parameter int unsigned       XLAT_WORDS = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    always_comb begin
        hit        = '0;
        hit.prot   = word_match(addr, OFS_PROT);
        hit.unprot = word_match(addr, OFS_UNPROT);
        hit.lock   = word_match(addr, OFS_LOCK);
        hit.rcfg   = word_match(addr, OFS_RCFG);
        hit.rsel   = word_match(addr, OFS_RSEL);
        hit.xlat   = in_window(addr, XLAT_BASE, XLAT_WORDS);
    end
endmodule

// File: rtl/wprot_state.sv
module wprot_state #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic         lock_en,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] prot_o,
    output logic [N-1:0] lock_o
);
    logic [N-1:0] prot_q, lock_q, prot_d, lock_d, clr_mask;

    always_comb begin
        clr_mask = clr_en ? (wbits & ~lock_q) : '0;
        prot_d   = (prot_q | (set_en ? wbits : '0)) & ~clr_mask;
        lock_d   = lock_q | (lock_en ? wbits : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q <= '0;
            lock_q <= '0;
        end else begin
            prot_q <= prot_d;
            lock_q <= lock_d;
        end
    end

    assign prot_o = prot_q;
    assign lock_o = lock_q;

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (($past(lock_q) & ~lock_q) == '0));

    p_locked_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (($past(lock_q & prot_q) & ~prot_q) == '0));

    p_protect_sets_r2: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((prot_q & $past(wbits)) == $past(wbits)));

    p_unprot_clears_r3: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((prot_q & $past(wbits & ~lock_q)) == '0));
endmodule

// File: rtl/wprot_guard_reg.sv
module wprot_guard_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_hit,
    input  logic         blocked,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= '0;
        else if (wr_hit && !blocked)
            q_r <= wdata;
    end

    assign q = q_r;

    // Covers R8 and R9: a blocked write leaves the value alone
    p_blocked_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && blocked) |=> (q_r == $past(q_r)));

    p_open_load_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !blocked) |=> (q_r == $past(wdata)));
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter logic [ADDR_W-1:0] XLAT_BASE  = 12'h040,
    parameter int unsigned       XLAT_WORDS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic                xlat_wr_o,
    output logic [N_GROUP-1:0]  guard_open_o,
    output logic [RCFG_W-1:0]   region_cfg_o,
    output logic [RSEL_W-1:0]   region_sel_o
);
    hit_t                 hit;
    logic [PROT_BITS-1:0] prot, lock;
    logic [DATA_W-1:0]    rd_mux, rdata_q;
    logic                 rvalid_q;

    wprot_decode #(.XLAT_BASE(XLAT_BASE), .XLAT_WORDS(XLAT_WORDS)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    wprot_state #(.N(PROT_BITS)) u_state (
        .clk     (clk),
        .rst     (rst),
        .set_en  (bus_wr && hit.prot),
        .clr_en  (bus_wr && hit.unprot),
        .lock_en (bus_wr && hit.lock),
        .wbits   (bus_wdata[PROT_BITS-1:0]),
        .prot_o  (prot),
        .lock_o  (lock)
    );

    wprot_guard_reg #(.W(RCFG_W)) u_rcfg (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (bus_wr && hit.rcfg),
        .blocked (prot[BIT_RCFG]),
        .wdata   (bus_wdata[RCFG_W-1:0]),
        .q       (region_cfg_o)
    );

    wprot_guard_reg #(.W(RSEL_W)) u_rsel (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (bus_wr && hit.rsel),
        .blocked (prot[BIT_RSEL]),
        .wdata   (bus_wdata[RSEL_W-1:0]),
        .q       (region_sel_o)
    );

    assign guard_open_o = {~prot[BIT_RSEL], ~prot[BIT_RCFG], ~prot[BIT_XLAT]};
    assign xlat_wr_o    = bus_wr && hit.xlat && !prot[BIT_XLAT];

    always_comb begin
        rd_mux = '0;
        if (hit.prot || hit.unprot) rd_mux[PROT_BITS-1:0] = prot;
        else if (hit.lock)          rd_mux[PROT_BITS-1:0] = lock;
        else if (hit.rcfg)          rd_mux[RCFG_W-1:0]    = region_cfg_o;
        else if (hit.rsel)          rd_mux[RSEL_W-1:0]    = region_sel_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    p_rd_latency_r12: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> (bus_rdata[DATA_W-1:PROT_BITS] == '0));

    p_xlat_gate_r10: assert property (@(posedge clk) disable iff (rst)
        xlat_wr_o |-> guard_open_o[0]);

    p_next_cycle_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit.prot && bus_wdata[BIT_XLAT]) |=> !guard_open_o[0]);
endmodule

// File: tb/tb_wprot_ctrl.sv
`timescale 1ns/1ps
module tb_wprot_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        xlat_wr_o;
    logic [2:0]  guard_open_o;
    logic [2:0]  region_cfg_o;
    logic [0:0]  region_sel_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always #4 clk = ~clk;

    wprot_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .xlat_wr_o(xlat_wr_o),
        .guard_open_o(guard_open_o), .region_cfg_o(region_cfg_o),
        .region_sel_o(region_sel_o)
    );

    // Monitor: pops expected read data when the design returns it
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL R12: unexpected read data %h, expected none", bus_rdata);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: read %h, expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_val(input logic [31:0] act, input logic [31:0] e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %h, expected %h", tag, act, e);
        end
    endtask

    task automatic xlat_try(input logic [11:0] a, input logic e, input string tag);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = 32'hA5A5_A5A5;
        #1;
        check_val({31'd0, xlat_wr_o}, {31'd0, e}, tag);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check_val({29'd0, guard_open_o}, 32'h7, "R1 guard_open");
        do_read(12'h200, 32'h0, "R1 prot");
        do_read(12'h208, 32'h0, "R1 lock");
        do_read(12'h500, 32'h0, "R1 rcfg");
        do_read(12'h504, 32'h0, "R1 rsel");

        // R8 / R9 open writes
        do_write(12'h500, 32'hFFFF_FFF5);
        do_read(12'h500, 32'h5, "R8 open write");
        do_write(12'h504, 32'h1);
        do_read(12'h504, 32'h1, "R9 open write");
        xlat_try(12'h044, 1'b1, "R10 open window");
        xlat_try(12'h080, 1'b0, "R10 outside window");

        // R2 set bits, OR behaviour, readback at both offsets
        do_write(12'h200, 32'h3);
        do_read(12'h200, 32'h3, "R2 prot read");
        do_write(12'h200, 32'h10);
        do_read(12'h204, 32'h13, "R2 OR set via unprot offset");
        // R6 upper bits ignored
        do_write(12'h200, 32'hFFFF_FFE0);
        do_read(12'h200, 32'h13, "R6 upper bits ignored");
        do_read(12'h300, 32'h0, "R12 unmapped reads zero");

        // R7 / R10 / R9 / R8 gating with bits 0,1,4 set
        check_val({29'd0, guard_open_o}, 32'h2, "R7 guard_open map");
        xlat_try(12'h07C, 1'b0, "R10 blocked window");
        do_write(12'h504, 32'h0);
        do_read(12'h504, 32'h1, "R9 blocked write");
        do_write(12'h500, 32'h2);
        do_read(12'h500, 32'h2, "R8 neighbour bits do not block");

        // R3 clear
        do_write(12'h204, 32'h11);
        do_read(12'h200, 32'h2, "R3 unprotect");
        check_val({29'd0, guard_open_o}, 32'h7, "R7 bit1 gates nothing");
        xlat_try(12'h040, 1'b1, "R7 xlat open with bit1 set");

        // R11 next-cycle effect: protect then guarded write back to back
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h200; bus_wdata = 32'h8;
        @(negedge clk);
        bus_addr = 12'h500; bus_wdata = 32'h7;
        @(negedge clk);
        bus_wr = 1'b0;
        do_read(12'h500, 32'h2, "R11 write after protect dropped");
        do_read(12'h200, 32'hA, "R11 prot state");

        // R4 lock
        do_write(12'h208, 32'hFFFF_FF0C);
        do_read(12'h208, 32'h0C, "R4 lock set");
        do_write(12'h208, 32'h0);
        do_read(12'h208, 32'h0C, "R4 lock sticky");
        // R5 locked bits ignore unprotect
        do_write(12'h204, 32'h1F);
        do_read(12'h200, 32'h08, "R5 locked bit survives");
        do_read(12'h208, 32'h0C, "R4 unprotect leaves lock");
        do_write(12'h200, 32'h04);
        do_read(12'h204, 32'h0C, "R5 protect still sets");
        do_write(12'h204, 32'h04);
        do_read(12'h200, 32'h0C, "R5 locked bit2 kept");
        do_write(12'h500, 32'h6);
        do_read(12'h500, 32'h2, "R8 locked protect blocks");

        // R1 reset clears lock
        do_reset();
        do_read(12'h208, 32'h0, "R1 lock after reset");
        do_read(12'h200, 32'h0, "R1 prot after reset");
        do_read(12'h500, 32'h0, "R1 rcfg after reset");

        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
            checks++; errors++;
            $display("FAIL R12: %0d reads unanswered, expected 0", sbq.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule